// File: doc/BRIEF.md
# Delay-Trigger Channel Status and Sequence-Error Logic

This block holds the status of one channel of a programmable delay trigger unit. The channel has up to eight pre-trigger lanes. Each lane has a delay compare value and an enable bit, and every lane is compared against a shared free-running counter supplied from outside. When the counter equals a lane's delay, the block records a hit flag for that lane. If the lane is enabled, the hit is also offered to the attached converter as a trigger.

The converter accepts one conversion at a time per channel. An accepted trigger marks the converter busy until a conversion-done pulse arrives. A trigger from an enabled lane that arrives while the converter is busy is rejected and raises that lane's sequence-error flag. When several enabled lanes fire together on an idle converter, the lowest-numbered lane wins and the rest are recorded as errors.

Both flag sets are read through one 32-bit status word and are written through a plain write port. The two flag sets use opposite clear conventions.

Top module: `pdt_chan_status`

## Requirements
- R1: Status bits 31..24 and 15..8 always read 0. In the hit field (bits 16+m) and the error field (bits m), every lane index m at or above NUM_PT reads 0.
- R2: Hit flag m (status bit 16+m) is set at the clock edge where `cnt_val` equals delay m, whether or not lane m is enabled. The new value is visible after that edge.
- R3: A write with `wr_data` bit 16+m equal to 0 clears hit flag m. A 1 in that bit leaves the flag unchanged.
- R4: Lane m is offered to the converter only when `pt_en[m]` is 1. An accepted trigger appears on `trg_o` as a one-cycle one-hot pulse in the cycle after the match.
- R5: An accepted trigger sets `conv_busy_o` in the same cycle as the `trg_o` pulse. Busy stays set until a cycle with `conv_done` high, and it is clear after that edge.
- R6: An enabled lane that matches while `conv_busy_o` is 1 sets error flag m (status bit m). No `trg_o` pulse is produced for that lane.
- R7: A write with `wr_data` bit m equal to 1 clears error flag m. A 0 in that bit leaves the flag unchanged.
- R8: When several enabled lanes match in the same cycle while the converter is idle, only the lowest index is accepted. Each of the other matching lanes sets its error flag.
- R9: When a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R10: After reset, the status word, `trg_o` and `conv_busy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Shared counter value |
| dly_flat | input | NUM_PT*CNT_W | Delay values, lane m in bits [m*CNT_W +: CNT_W] |
| pt_en | input | NUM_PT | Per-lane enable |
| conv_done | input | 1 | Converter end-of-conversion pulse |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Status write data |
| trg_o | output | NUM_PT | One-hot trigger pulse to the converter |
| conv_busy_o | output | 1 | Converter busy with a trigger from this channel |
| stat_o | output | 32 | Status word: hit flags at 23..16, error flags at 7..0 |

## Verification
The bench builds the block with NUM_PT = 4 and CNT_W = 8. With four lanes, lanes 4 to 7 are not implemented, so writing all ones to the status word shows whether any of those bits leak through. Four lanes also give room for two lanes to match in the same cycle together with a third lane that is disabled. The 8-bit counter keeps the delay values short, so each scenario can place matches on chosen cycles, including a match that lands in the same cycle as a clearing write.

// File: rtl/pdt_stat_pkg.sv
package pdt_stat_pkg;
   localparam int STAT_W    = 32;
   localparam int MAX_PT    = 8;
   localparam int HIT_LSB   = 16;
   localparam int ERR_LSB   = 0;
endpackage

// File: rtl/pdt_cmp_bank.sv
module pdt_cmp_bank #(
   parameter int NUM_PT = 8,
   parameter int CNT_W  = 16
) (
   input  logic [CNT_W-1:0]        cnt_val,
   input  logic [NUM_PT*CNT_W-1:0] dly_flat,
   output logic [NUM_PT-1:0]       hit
);
   for (genvar m = 0; m < NUM_PT; m++) begin : g_lane
      assign hit[m] = (cnt_val == dly_flat[m*CNT_W +: CNT_W]);
   end
endmodule

// File: rtl/pdt_seq_arb.sv
module pdt_seq_arb #(
   parameter int NUM_PT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_PT-1:0] fire,
   input  logic              conv_done,
   output logic [NUM_PT-1:0] trg_q,
   output logic              busy_q,
   output logic [NUM_PT-1:0] reject
);
   logic [NUM_PT-1:0] low_pick;
   logic [NUM_PT-1:0] grant;

   if (NUM_PT == 1) begin : g_single
      assign low_pick = fire;
   end else begin : g_multi
      assign low_pick = fire & (~fire + NUM_PT'(1));
   end

   assign grant  = busy_q ? '0 : low_pick;
   assign reject = fire & ~grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trg_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         trg_q  <= grant;
         busy_q <= (busy_q & ~conv_done) | (|grant);
      end
   end

   // R5
   done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && conv_done) |=> !busy_q);
   // R8
   single_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trg_q));
endmodule

// File: rtl/pdt_flag_bank.sv
module pdt_flag_bank #(
   parameter int NUM_PT     = 8,
   parameter bit CLR_ON_ONE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_PT-1:0] set_vec,
   input  logic              wr_en,
   input  logic [NUM_PT-1:0] wr_bits,
   output logic [NUM_PT-1:0] flag_q
);
   logic [NUM_PT-1:0] clr_vec;

   if (CLR_ON_ONE) begin : g_w1c
      assign clr_vec = wr_en ? wr_bits : '0;
   end else begin : g_w0c
      assign clr_vec = wr_en ? ~wr_bits : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= set_vec | (flag_q & ~clr_vec);
   end

   for (genvar m = 0; m < NUM_PT; m++) begin : g_chk
      // R9
      set_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[m] |=> flag_q[m]);
      // R3
      clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (wr_bits[m] == CLR_ON_ONE) && !set_vec[m]) |=> !flag_q[m]);
      // R7
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_vec[m] && !(wr_en && (wr_bits[m] == CLR_ON_ONE)))
         |=> (flag_q[m] == $past(flag_q[m])));
   end
endmodule

// File: rtl/pdt_chan_status.sv
module pdt_chan_status
   import pdt_stat_pkg::*;
#(
   parameter int NUM_PT = 8,
   parameter int CNT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        cnt_val,
   input  logic [NUM_PT*CNT_W-1:0] dly_flat,
   input  logic [NUM_PT-1:0]       pt_en,
   input  logic                    conv_done,
   input  logic                    wr_en,
   input  logic [STAT_W-1:0]       wr_data,
   output logic [NUM_PT-1:0]       trg_o,
   output logic                    conv_busy_o,
   output logic [STAT_W-1:0]       stat_o
);
   if (NUM_PT < 1 || NUM_PT > MAX_PT) begin : g_bad_lanes
      $error("pdt_chan_status: NUM_PT out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pdt_chan_status: CNT_W must be positive");
   end

   logic [NUM_PT-1:0] hit;
   logic [NUM_PT-1:0] fire;
   logic [NUM_PT-1:0] reject;
   logic [NUM_PT-1:0] hit_q;
   logic [NUM_PT-1:0] err_q;
   logic              unused_wr;

   assign unused_wr = ^wr_data;

   pdt_cmp_bank #(.NUM_PT(NUM_PT), .CNT_W(CNT_W)) cmp_i (
      .cnt_val (cnt_val),
      .dly_flat(dly_flat),
      .hit     (hit)
   );

   assign fire = hit & pt_en;

   pdt_seq_arb #(.NUM_PT(NUM_PT)) arb_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .conv_done(conv_done),
      .trg_q    (trg_o),
      .busy_q   (conv_busy_o),
      .reject   (reject)
   );

   pdt_flag_bank #(.NUM_PT(NUM_PT), .CLR_ON_ONE(1'b0)) hit_flags_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(hit),
      .wr_en  (wr_en),
      .wr_bits(wr_data[HIT_LSB +: NUM_PT]),
      .flag_q (hit_q)
   );

   pdt_flag_bank #(.NUM_PT(NUM_PT), .CLR_ON_ONE(1'b1)) err_flags_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(reject),
      .wr_en  (wr_en),
      .wr_bits(wr_data[ERR_LSB +: NUM_PT]),
      .flag_q (err_q)
   );

   always_comb begin
      stat_o = '0;
      stat_o[HIT_LSB +: NUM_PT] = hit_q;
      stat_o[ERR_LSB +: NUM_PT] = err_q;
   end

   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[31:24] == 8'h00) && (stat_o[15:8] == 8'h00));
   // R6
   no_trigger_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_busy_o |=> (trg_o == '0));
   // R6
   busy_fire_errors_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_busy_o && (|(hit & pt_en))) |=> (|err_q));
   // R4
   disabled_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trg_o & ~$past(pt_en)) == '0);
endmodule

// File: tb/pdt_chan_status_tb_top.sv
module pdt_chan_status_tb_top;
   localparam int NP = 4;
   localparam int CW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [CW-1:0]   cnt_val = '0;
   logic [NP*CW-1:0] dly_flat = {NP{8'd200}};
   logic [NP-1:0]   pt_en = '0;
   logic            conv_done = 1'b0;
   logic            wr_en = 1'b0;
   logic [31:0]     wr_data = '0;
   logic [NP-1:0]   trg_o;
   logic            conv_busy_o;
   logic [31:0]     stat_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pdt_chan_status #(.NUM_PT(NP), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .dly_flat(dly_flat),
      .pt_en(pt_en), .conv_done(conv_done), .wr_en(wr_en), .wr_data(wr_data),
      .trg_o(trg_o), .conv_busy_o(conv_busy_o), .stat_o(stat_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_dly(input int lane, input logic [CW-1:0] v);
      dly_flat[lane*CW +: CW] = v;
   endtask

   task automatic t_reset();
      check("R10 stat", stat_o, 32'h0);
      check("R10 trg", {28'h0, trg_o}, 32'h0);
      check("R10 busy", {31'h0, conv_busy_o}, 32'h0);
   endtask

   task automatic t_hit_disabled();
      @(negedge clk); set_dly(1, 8'd5); pt_en = 4'b0000; cnt_val = 8'd5;
      tick();
      check("R2 hit flag lane1", stat_o, 32'h0002_0000);
      check("R4 disabled lane no trigger", {28'h0, trg_o}, 32'h0);
      @(negedge clk); cnt_val = 8'd0;
   endtask

   task automatic t_hit_clear();
      @(negedge clk); wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
      tick();
      check("R3 write one keeps hit", stat_o, 32'h0002_0000);
      @(negedge clk); wr_data = 32'h0;
      tick();
      check("R3 write zero clears hit", stat_o, 32'h0);
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic t_accept();
      @(negedge clk); pt_en = 4'b0001; set_dly(0, 8'd10); cnt_val = 8'd10;
      tick();
      check("R4 trigger pulse lane0", {28'h0, trg_o}, 32'h1);
      check("R5 busy set", {31'h0, conv_busy_o}, 32'h1);
      check("R2 hit lane0", stat_o, 32'h0001_0000);
      @(negedge clk); cnt_val = 8'd0;
      tick();
      check("R4 pulse is one cycle", {28'h0, trg_o}, 32'h0);
      check("R5 busy holds", {31'h0, conv_busy_o}, 32'h1);
   endtask

   task automatic t_busy_err();
      @(negedge clk); pt_en = 4'b0101; set_dly(2, 8'd20); cnt_val = 8'd20;
      tick();
      check("R6 no trigger while busy", {28'h0, trg_o}, 32'h0);
      check("R6 error lane2", stat_o, 32'h0005_0004);
      @(negedge clk); cnt_val = 8'd0; wr_en = 1'b1; wr_data = 32'h00FF_0000;
      tick();
      check("R7 write zero keeps error", stat_o, 32'h0005_0004);
      @(negedge clk); wr_data = 32'h00FF_0004;
      tick();
      check("R7 write one clears error", stat_o, 32'h0005_0000);
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic t_done();
      @(negedge clk); conv_done = 1'b1;
      tick();
      check("R5 busy cleared by done", {31'h0, conv_busy_o}, 32'h0);
      @(negedge clk); conv_done = 1'b0; cnt_val = 8'd10;
      tick();
      check("R5 new trigger after done", {28'h0, trg_o}, 32'h1);
      check("R6 no error when idle", stat_o & 32'hFF, 32'h0);
      @(negedge clk); cnt_val = 8'd0; conv_done = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_00FF;
      tick();
      check("R3 R7 full clear", stat_o, 32'h0);
      @(negedge clk); conv_done = 1'b0; wr_en = 1'b0;
   endtask

   task automatic t_multi();
      @(negedge clk); pt_en = 4'b1010; set_dly(1, 8'd30); set_dly(3, 8'd30); cnt_val = 8'd30;
      tick();
      check("R8 lowest lane accepted", {28'h0, trg_o}, 32'h2);
      check("R8 other lane errors", stat_o, 32'h000A_0008);
      @(negedge clk); cnt_val = 8'd0; conv_done = 1'b1;
      tick();
      @(negedge clk); conv_done = 1'b0;
   endtask

   task automatic t_set_wins();
      @(negedge clk); cnt_val = 8'd30; wr_en = 1'b1; wr_data = 32'h0000_0008;
      tick();
      check("R9 set beats clear", stat_o, 32'h000A_0008);
      check("R8 lane1 accepted again", {28'h0, trg_o}, 32'h2);
      @(negedge clk); cnt_val = 8'd0; wr_data = 32'h0000_00FF; conv_done = 1'b1;
      tick();
      check("R9 clear after set", stat_o, 32'h0);
      @(negedge clk); wr_en = 1'b0; conv_done = 1'b0;
   endtask

   task automatic t_unimpl();
      @(negedge clk);
      pt_en = 4'b1111; dly_flat = {NP{8'd40}}; cnt_val = 8'd40;
      wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
      tick();
      check("R1 upper lanes and reserved zero", stat_o, 32'h000F_000E);
      @(negedge clk); cnt_val = 8'd0; wr_en = 1'b0;
      tick();
      check("R1 stable after write", stat_o, 32'h000F_000E);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      t_reset();
      t_hit_disabled();
      t_hit_clear();
      t_accept();
      t_busy_err();
      t_done();
      t_multi();
      t_set_wins();
      t_unimpl();
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule